// File: doc/BRIEF.md
# Register Bus Request Legality Gate

This block sits between the channel A side of a TileLink Uncached Lightweight (TL-UL) device port and a register file. It decides in the acceptance cycle whether each request is legal. Legal requests become a one-cycle read or write strobe toward the register file. Illegal requests are dropped with no side effect and are answered with an error.

The checks fall into two groups. The first group holds for any TL-UL device: the opcode, the size, address alignment and the byte-lane mask. The second group is local to this register block. It covers unmapped addresses (flagged only when the device-mode strap is set), writes that are not word aligned, and writes whose byte enables do not cover the whole target register. An external address decoder supplies, for the current request address, whether the address is mapped and how many bytes wide the register there is.

The response is registered and returned on channel D. Only one transaction is in flight at a time: a new request is refused while a response is waiting to be taken.

Top module: `tlul_legality_gate`

## Requirements
- R1: Only opcodes 0 (full write), 1 (partial write) and 4 (read) are legal; any other value of `a_opcode` is an error.
- R2: A request with `a_size` = 3 is an error.
- R3: An address that is not aligned to the size is an error. For size 1 this means `a_address[0]` = 1; for size 2 it means `a_address[1:0]` != 0.
- R4: The active lanes are one lane at `a_address[1:0]` for size 0, lanes 1:0 or 3:2 (chosen by `a_address[1]`) for size 1, and all four lanes for size 2. A mask bit set outside the active lanes is an error; for example, address 0, size 0, mask 0b0010 is an error.
- R5: A full write (opcode 0) whose mask is not exactly the active lanes is an error.
- R6: With `dev_mode` = 1, a request to an address where `dec_hit` = 0 is an error. With `dev_mode` = 0, such a request is not an error: it raises no strobe, and a read returns zero data.
- R7: Any write (opcode 0 or 1) with `a_address[1:0]` != 0 is an error.
- R8: A write to a mapped address is an error unless its mask covers lanes 0 through `dec_bytes_m1` (register width = `dec_bytes_m1` + 1 bytes).
- R9: A legal read of a mapped address raises `reg_re` in the acceptance cycle and returns the full `reg_rdata` word whatever the mask. A legal write of a mapped address raises `reg_we` in the acceptance cycle. `d_opcode` is 1 (data acknowledge) for opcode 4 and 0 (plain acknowledge) for every other opcode.
- R10: An illegal request raises neither strobe. Its response has `d_error` = 1 and `d_data` = 0, and it echoes the request's source and size.
- R11: A request is accepted when `a_valid` and `a_ready` are both high, and its response is valid from the next cycle. `a_ready` stays low while a response is pending. The response holds stable until `d_ready` is high.
- R12: After reset, `d_valid` is 0 and `a_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Channel A request valid |
| a_ready | output | 1 | Channel A request accepted when high |
| a_opcode | input | 3 | Request opcode |
| a_size | input | 2 | log2 of the request byte count |
| a_source | input | SW | Requester tag |
| a_address | input | AW | Byte address |
| a_mask | input | 4 | Byte-lane enables |
| a_data | input | 32 | Write data |
| dev_mode | input | 1 | Strap: flag unmapped accesses as errors |
| dec_hit | input | 1 | Decoder: the address is mapped |
| dec_bytes_m1 | input | 2 | Decoder: target register width in bytes minus one |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_addr | output | AW | Register byte address |
| reg_wdata | output | 32 | Register write data |
| reg_be | output | 4 | Register byte enables |
| reg_rdata | input | 32 | Register read data, same cycle as `reg_re` |
| d_valid | output | 1 | Channel D response valid |
| d_ready | input | 1 | Channel D response taken when high |
| d_opcode | output | 3 | Response opcode |
| d_size | output | 2 | Echoed request size |
| d_source | output | SW | Echoed requester tag |
| d_error | output | 1 | Request was illegal |
| d_data | output | 32 | Read data, zero on error |

## Verification
The strobes and `reg_addr`/`reg_wdata` are combinational in the acceptance cycle. The bench therefore samples them one time step after driving the request on a falling edge, before the accepting rising edge. The response fields come from one register stage, so they are checked on the falling edge that follows the accepting rising edge. `d_valid` falling and `a_ready` rising are checked one edge after `d_ready` is raised. Every opcode, size, low address and mask combination is swept against an arithmetic legality model. A second sweep covers mapping, device mode and register width. Some transactions hold `d_ready` low for an extra cycle while presenting an intruding write, to confirm that the gate stays closed.

// File: rtl/tlgate_pkg.sv
package tlgate_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int SIZE_W  = 2;
    localparam int OP_W    = 3;

    localparam logic [OP_W-1:0] OP_WR_FULL = 3'd0;
    localparam logic [OP_W-1:0] OP_WR_PART = 3'd1;
    localparam logic [OP_W-1:0] OP_RD      = 3'd4;

    typedef enum logic [OP_W-1:0] {
        RSP_ACK      = 3'd0,
        RSP_ACK_DATA = 3'd1
    } rsp_op_e;

    typedef struct packed {
        logic bad_op;
        logic bad_size;
        logic misaligned;
        logic stray_lanes;
        logic full_not_full;
    } proto_err_t;

    typedef struct packed {
        logic unmapped;
        logic sub_word_write;
        logic short_write;
    } dev_err_t;

    function automatic logic is_write(logic [OP_W-1:0] op);
        return (op == OP_WR_FULL) || (op == OP_WR_PART);
    endfunction

    function automatic logic [LANES-1:0] lane_span(logic [SIZE_W-1:0] sz, logic [1:0] lo);
        case (sz)
            2'd0:    return 4'b0001 << lo;
            2'd1:    return lo[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [LANES-1:0] width_need(logic [1:0] bytes_m1);
        case (bytes_m1)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            2'd2:    return 4'b0111;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/tlgate_proto_chk.sv
module tlgate_proto_chk
    import tlgate_pkg::*;
(
    input  logic [OP_W-1:0]   opcode,
    input  logic [SIZE_W-1:0] size,
    input  logic [1:0]        addr_lo,
    input  logic [LANES-1:0]  mask,
    output proto_err_t        err
);
    logic [LANES-1:0] span;

    always_comb begin
        span              = lane_span(size, addr_lo);
        err.bad_op        = !(is_write(opcode) || opcode == OP_RD);
        err.bad_size      = (size == 2'd3);
        err.misaligned    = ((size == 2'd1) && addr_lo[0]) ||
                            ((size == 2'd2) && (addr_lo != 2'd0));
        err.stray_lanes   = |(mask & ~span);
        err.full_not_full = (opcode == OP_WR_FULL) && (mask != span);
    end
endmodule

// File: rtl/tlgate_dev_chk.sv
module tlgate_dev_chk
    import tlgate_pkg::*;
(
    input  logic             wr,
    input  logic [1:0]       addr_lo,
    input  logic [LANES-1:0] mask,
    input  logic             dev_mode,
    input  logic             hit,
    input  logic [1:0]       bytes_m1,
    output dev_err_t         err
);
    logic [LANES-1:0] need;

    always_comb begin
        need               = width_need(bytes_m1);
        err.unmapped       = dev_mode && !hit;
        err.sub_word_write = wr && (addr_lo != 2'd0);
        err.short_write    = wr && hit && ((mask & need) != need);
    end
endmodule

// File: rtl/tlgate_resp.sv
module tlgate_resp
    import tlgate_pkg::*;
#(
    parameter int SW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              is_rd,
    input  logic              err,
    input  logic [DATA_W-1:0] rdata,
    input  logic [SW-1:0]     source,
    input  logic [SIZE_W-1:0] size,
    input  logic              d_ready,
    output logic              d_valid,
    output logic [OP_W-1:0]   d_opcode,
    output logic [SIZE_W-1:0] d_size,
    output logic [SW-1:0]     d_source,
    output logic              d_error,
    output logic [DATA_W-1:0] d_data
);
    rsp_op_e op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            d_valid  <= 1'b0;
            op_q     <= RSP_ACK;
            d_size   <= '0;
            d_source <= '0;
            d_error  <= 1'b0;
            d_data   <= '0;
        end else if (accept) begin
            d_valid  <= 1'b1;
            op_q     <= is_rd ? RSP_ACK_DATA : RSP_ACK;
            d_size   <= size;
            d_source <= source;
            d_error  <= err;
            d_data   <= err ? '0 : rdata;
        end else if (d_ready) begin
            d_valid  <= 1'b0;
        end
    end

    assign d_opcode = op_q;
endmodule

// File: rtl/tlul_legality_gate.sv
module tlul_legality_gate
    import tlgate_pkg::*;
#(
    parameter int AW = 12,
    parameter int SW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic [OP_W-1:0]   a_opcode,
    input  logic [SIZE_W-1:0] a_size,
    input  logic [SW-1:0]     a_source,
    input  logic [AW-1:0]     a_address,
    input  logic [LANES-1:0]  a_mask,
    input  logic [DATA_W-1:0] a_data,
    input  logic              dev_mode,
    input  logic              dec_hit,
    input  logic [1:0]        dec_bytes_m1,
    output logic              reg_we,
    output logic              reg_re,
    output logic [AW-1:0]     reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic [LANES-1:0]  reg_be,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              d_valid,
    input  logic              d_ready,
    output logic [OP_W-1:0]   d_opcode,
    output logic [SIZE_W-1:0] d_size,
    output logic [SW-1:0]     d_source,
    output logic              d_error,
    output logic [DATA_W-1:0] d_data
);
    proto_err_t        p_err;
    dev_err_t          v_err;
    logic              wr, rd, any_err, accept, pass;
    logic [DATA_W-1:0] rd_word;

    assign wr = is_write(a_opcode);
    assign rd = (a_opcode == OP_RD);

    tlgate_proto_chk u_proto (
        .opcode  (a_opcode),
        .size    (a_size),
        .addr_lo (a_address[1:0]),
        .mask    (a_mask),
        .err     (p_err)
    );

    tlgate_dev_chk u_dev (
        .wr       (wr),
        .addr_lo  (a_address[1:0]),
        .mask     (a_mask),
        .dev_mode (dev_mode),
        .hit      (dec_hit),
        .bytes_m1 (dec_bytes_m1),
        .err      (v_err)
    );

    assign any_err = (|p_err) || (|v_err);
    assign a_ready = !d_valid;
    assign accept  = a_valid && a_ready;
    assign pass    = accept && !any_err && dec_hit;

    assign reg_we    = pass && wr;
    assign reg_re    = pass && rd;
    assign reg_addr  = a_address;
    assign reg_wdata = a_data;
    assign reg_be    = a_mask;
    assign rd_word   = reg_re ? reg_rdata : '0;

    tlgate_resp #(.SW(SW)) u_resp (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .is_rd    (rd),
        .err      (any_err),
        .rdata    (rd_word),
        .source   (a_source),
        .size     (a_size),
        .d_ready  (d_ready),
        .d_valid  (d_valid),
        .d_opcode (d_opcode),
        .d_size   (d_size),
        .d_source (d_source),
        .d_error  (d_error),
        .d_data   (d_data)
    );
endmodule

// File: rtl/tlgate_sva.sv
module tlgate_sva
    import tlgate_pkg::*;
#(
    parameter int SW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              a_valid,
    input logic              a_ready,
    input logic [OP_W-1:0]   a_opcode,
    input logic [SIZE_W-1:0] a_size,
    input logic [1:0]        addr_lo,
    input logic [LANES-1:0]  a_mask,
    input logic              dec_hit,
    input logic [1:0]        dec_bytes_m1,
    input logic              reg_we,
    input logic              reg_re,
    input logic              d_valid,
    input logic              d_ready,
    input logic              d_error,
    input logic [DATA_W-1:0] d_data,
    input logic [SW-1:0]     d_source
);
    logic [LANES-1:0] need;
    assign need = width_need(dec_bytes_m1);

    assert_bad_op_R1: assert property (@(posedge clk) disable iff (rst)
        (a_valid && a_ready && a_opcode != 3'd0 && a_opcode != 3'd1 && a_opcode != 3'd4)
        |=> d_error);

    assert_bad_size_R2: assert property (@(posedge clk) disable iff (rst)
        (a_valid && a_ready && a_size == 2'd3) |=> d_error);

    assert_mapped_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_we || reg_re) |-> dec_hit);

    assert_word_write_R7: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (addr_lo == 2'd0));

    assert_cover_width_R8: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> ((a_mask & need) == need));

    assert_err_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (d_valid && d_error) |-> (d_data == '0));

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_we, reg_re}));

    assert_resp_next_R11: assert property (@(posedge clk) disable iff (rst)
        (a_valid && a_ready) |=> d_valid);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (d_valid && !d_ready) |=>
        (d_valid && $stable(d_source) && $stable(d_data) && $stable(d_error)));

    assert_gate_busy_R11: assert property (@(posedge clk) disable iff (rst)
        d_valid |-> !a_ready);
endmodule

bind tlul_legality_gate tlgate_sva #(.SW(SW)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .a_valid      (a_valid),
    .a_ready      (a_ready),
    .a_opcode     (a_opcode),
    .a_size       (a_size),
    .addr_lo      (a_address[1:0]),
    .a_mask       (a_mask),
    .dec_hit      (dec_hit),
    .dec_bytes_m1 (dec_bytes_m1),
    .reg_we       (reg_we),
    .reg_re       (reg_re),
    .d_valid      (d_valid),
    .d_ready      (d_ready),
    .d_error      (d_error),
    .d_data       (d_data),
    .d_source     (d_source)
);

// File: tb/tlul_legality_gate_test.sv
`timescale 1ns/1ps
module tlul_legality_gate_test;
    localparam int AW = 12;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          a_valid = 1'b0;
    logic          a_ready;
    logic [2:0]    a_opcode = '0;
    logic [1:0]    a_size = '0;
    logic [SW-1:0] a_source = '0;
    logic [AW-1:0] a_address = '0;
    logic [3:0]    a_mask = '0;
    logic [31:0]   a_data = '0;
    logic          dev_mode = 1'b0;
    logic          dec_hit = 1'b0;
    logic [1:0]    dec_bytes_m1 = '0;
    logic          reg_we, reg_re;
    logic [AW-1:0] reg_addr;
    logic [31:0]   reg_wdata;
    logic [3:0]    reg_be;
    logic [31:0]   reg_rdata;
    logic          d_valid;
    logic          d_ready = 1'b0;
    logic [2:0]    d_opcode;
    logic [1:0]    d_size;
    logic [SW-1:0] d_source;
    logic          d_error;
    logic [31:0]   d_data;

    int n_checks = 0;
    int n_fail   = 0;
    int n_txn    = 0;

    always #4 clk = ~clk;

    assign reg_rdata = 32'hC300_0000 | 32'(reg_addr);

    tlul_legality_gate #(.AW(AW), .SW(SW)) uut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit ref_err(input int op, input int sz, input int lo,
                                   input int m, input bit hit, input int bm1,
                                   input bit dev, output string why);
        bit wr;
        int n, lanes, need;
        wr  = (op == 0) || (op == 1);
        why = "R9";
        if (!(wr || op == 4)) begin why = "R1"; return 1; end
        if (sz == 3) begin why = "R2"; return 1; end
        n = 1 << sz;
        if (lo % n != 0) begin why = "R3"; return 1; end
        lanes = ((1 << n) - 1) << (lo - lo % n);
        if ((m & ~lanes & 15) != 0) begin why = "R4"; return 1; end
        if (op == 0 && m != lanes) begin why = "R5"; return 1; end
        if (dev && !hit) begin why = "R6"; return 1; end
        if (wr && lo != 0) begin why = "R7"; return 1; end
        if (wr && hit) begin
            need = (1 << (bm1 + 1)) - 1;
            if ((m & need) != need) begin why = "R8"; return 1; end
        end
        if (!hit) why = "R6";
        return 0;
    endfunction

    task automatic txn(input int op, input int sz, input int lo, input int m,
                       input bit hit, input int bm1, input bit dev, input bit stall);
        bit e, wr, rd;
        string why;
        logic [AW-1:0] addr;
        logic [SW-1:0] src;
        logic [31:0] exp_data;
        n_txn++;
        addr = AW'(((n_txn * 16) & 12'hFF0) | lo);
        src  = SW'(n_txn * 7);
        e    = ref_err(op, sz, lo, m, hit, bm1, dev, why);
        wr   = (op == 0) || (op == 1);
        rd   = (op == 4);
        exp_data = (!e && rd && hit) ? (32'hC300_0000 | 32'(addr)) : 32'h0;

        @(negedge clk);
        a_valid = 1'b1; a_opcode = 3'(op); a_size = 2'(sz); a_address = addr;
        a_mask = 4'(m); a_source = src; a_data = ~32'(n_txn);
        dec_hit = hit; dec_bytes_m1 = 2'(bm1); dev_mode = dev;
        #1;
        chk(a_ready == 1'b1, "R11", "a_ready idle", 32'(a_ready), 32'h1);
        chk(reg_we == (!e && wr && hit), (e ? why : (hit ? "R9" : "R6")), "reg_we",
            32'(reg_we), 32'(!e && wr && hit));
        chk(reg_re == (!e && rd && hit), (e ? why : (hit ? "R9" : "R6")), "reg_re",
            32'(reg_re), 32'(!e && rd && hit));
        if (!e && wr && hit)
            chk(reg_wdata == ~32'(n_txn) && reg_be == 4'(m), "R9", "write data/be",
                reg_wdata, ~32'(n_txn));
        @(negedge clk);
        a_valid = 1'b0;
        chk(d_valid == 1'b1, "R11", "d_valid after accept", 32'(d_valid), 32'h1);
        chk(d_error == e, why, "d_error", 32'(d_error), 32'(e));
        chk(d_data == exp_data, (e ? "R10" : why), "d_data", d_data, exp_data);
        chk(d_opcode == (rd ? 3'd1 : 3'd0), "R9", "d_opcode", 32'(d_opcode), rd ? 32'h1 : 32'h0);
        chk(d_source == src && d_size == 2'(sz), "R10", "echo source/size",
            {22'h0, d_size, d_source}, {22'h0, 2'(sz), src});
        if (stall) begin
            a_valid = 1'b1; a_opcode = 3'd0; a_size = 2'd2; a_mask = 4'hF;
            a_address = '0; dec_hit = 1'b1; dec_bytes_m1 = 2'd3;
            #1;
            chk(a_ready == 1'b0 && reg_we == 1'b0, "R11", "gate closed while pending",
                {30'h0, a_ready, reg_we}, 32'h0);
            @(negedge clk);
            a_valid = 1'b0;
            chk(d_valid == 1'b1 && d_source == src && d_data == exp_data, "R11", "held response",
                d_data, exp_data);
        end
        d_ready = 1'b1;
        @(negedge clk);
        d_ready = 1'b0;
        chk(d_valid == 1'b0 && a_ready == 1'b1, "R11", "response retired",
            {30'h0, d_valid, a_ready}, 32'h1);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(d_valid == 1'b0, "R12", "d_valid after reset", 32'(d_valid), 32'h0);
        chk(a_ready == 1'b1, "R12", "a_ready after reset", 32'(a_ready), 32'h1);

        // Directed corners
        txn(4, 0, 0, 2, 1'b1, 3, 1'b1, 1'b0);   // R4 stray lane
        txn(4, 1, 1, 3, 1'b1, 3, 1'b1, 1'b0);   // R3 misaligned
        txn(4, 2, 0, 1, 1'b1, 3, 1'b1, 1'b1);   // R9 partial-mask read
        txn(1, 0, 0, 1, 1'b1, 0, 1'b1, 1'b0);   // R8 one-byte register
        txn(1, 0, 0, 1, 1'b1, 1, 1'b1, 1'b0);   // R8 too short
        txn(0, 2, 0, 15, 1'b0, 3, 1'b0, 1'b0);  // R6 unmapped, dev 0

        // Sweep protocol space
        for (int op = 0; op < 8; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int lo = 0; lo < 4; lo++)
                    for (int m = 0; m < 16; m++)
                        txn(op, sz, lo, m, 1'b1, (m + lo) % 4, 1'b1, (m % 7) == 3);

        // Sweep device rules
        for (int k = 0; k < 3; k++)
            for (int dv = 0; dv < 2; dv++)
                for (int h = 0; h < 2; h++)
                    for (int bm = 0; bm < 4; bm++)
                        for (int lo = 0; lo < 4; lo += 2)
                            for (int m = 0; m < 16; m++)
                                txn((k == 2) ? 4 : k, (lo == 0) ? 2 : 0, lo, m, h[0], bm,
                                    dv[0], (m % 9) == 5);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule